// File: doc/BRIEF.md
# Hardwired Major-State Instruction Sequencer

This block is the control sequencer of a 16-bit processor that has no microcode. Each instruction walks through a chain of major states: Fetch, an optional operand-source phase, an optional operand-destination phase, Execute, and a Service phase for pending interrupts and traps. Each major state is a counted run of minor steps. A minor step is either an internal step, which always lasts one cycle, or a bus step, which raises a bus request and waits for the bus to report completion.

The surrounding decoder supplies the instruction class and the two 3-bit addressing modes. The sequencer captures them at the end of Fetch. It skips an operand phase whose mode is register-direct (mode 0), and it picks the minor-step pattern of each operand phase from the addressing mode. It marks the final destination read as a read that announces a following write. The write-back in Execute does not compute its address again: it drives the address that was held from the last completed read. The datapath, the full instruction decoder and bus arbitration sit outside this block.

Top module: `major_seq`

## Requirements
- R1: After reset the block is in Fetch (major code 0), minor step 0, with a plain read requested (bus_kind 1, bus_req 1).
- R2: Fetch has two steps: step 0 is a bus read (kind 1) and step 1 is an internal step. The class and both modes are captured when step 1 completes, and later changes to those inputs do not affect the current instruction.
- R3: The source phase (major code 1) is entered only for class 2 (two operands) with a non-zero source mode. Class 2 with source mode 0 goes on as if the source phase were absent.
- R4: The destination phase (major code 2) is entered for class 1 or class 2 with a non-zero destination mode. With destination mode 0, or with class 0 or 3 (no operand), the block goes straight on to Execute (major code 3).
- R5: The minor steps of an operand phase depend on its mode (I = internal, B = bus): mode 1 B; mode 2 I,B; mode 3 I,B,B; mode 4 I,B; mode 5 I,B,B; mode 6 B,I,B; mode 7 B,I,B,B.
- R6: The last step of the destination phase is a read-with-pending-write (kind 2). Every other read, in Fetch, Source, Destination and Service, is a plain read (kind 1).
- R7: Execute is one internal step. It is followed by a write step (kind 3) only when the captured write-back flag is set and the captured destination mode is non-zero.
- R8: During the Execute write step, bus_addr equals the address that was on addr_in when the last read step completed, whatever addr_in carries at that time.
- R9: When Execute completes, the block enters Service (major code 4) if irq_pend is high in that cycle, and Fetch otherwise. irq_pend at any other time has no effect.
- R10: Service is two plain-read bus steps (kind 1), followed by Fetch step 0.
- R11: While a bus step waits with bus_done low, the major state, the minor step, bus_req and bus_kind stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_class | input | 2 | Decoded class: 0 none, 1 one operand, 2 two operands, 3 none |
| src_mode | input | 3 | Source addressing mode |
| dst_mode | input | 3 | Destination addressing mode |
| wr_back | input | 1 | Instruction writes its destination back |
| bus_done | input | 1 | Current bus cycle has completed |
| irq_pend | input | 1 | Interrupt or trap pending |
| addr_in | input | 16 | Address computed by the datapath for the current read |
| major | output | 3 | Major state code |
| step | output | 3 | Minor step index within the major state |
| bus_req | output | 1 | A bus cycle is requested |
| bus_kind | output | 2 | 0 none, 1 read, 2 read with pending write, 3 write at held address |
| bus_addr | output | 16 | Bus address (held address during write steps) |

## Verification
Major state, step, bus_req and bus_kind are all decoded from registers. They change one clock edge after an internal step starts, or one edge after the cycle in which bus_done is seen high during a bus step. The bench drives inputs and samples outputs at the falling edge, so each check reads the settled result of the edge just taken. Captured decode inputs and irq_pend take effect at the edge that closes Fetch step 1 or Execute, so the bench sets them one half-cycle before that edge and scrambles the decode inputs right after it. The held write address is checked during the write step itself, after addr_in has been changed to an unrelated value.

// File: rtl/major_seq_pkg.sv
package major_seq_pkg;

    typedef enum logic [2:0] {
        MS_FETCH = 3'd0,
        MS_SRC   = 3'd1,
        MS_DST   = 3'd2,
        MS_EXEC  = 3'd3,
        MS_SERV  = 3'd4
    } major_e;

    typedef enum logic [1:0] {
        BK_NONE  = 2'd0,
        BK_READ  = 2'd1,
        BK_RDPW  = 2'd2,
        BK_WRHLD = 2'd3
    } bkind_e;

    typedef enum logic [1:0] {
        IC_NONE = 2'd0,
        IC_ONE  = 2'd1,
        IC_TWO  = 2'd2,
        IC_RSV  = 2'd3
    } iclass_e;

    typedef struct packed {
        logic   is_bus;
        bkind_e kind;
        logic   last;
    } step_t;

    localparam int MODE_W = 3;

    // number of minor steps an operand phase takes for a mode
    function automatic logic [2:0] opnd_len(input logic [MODE_W-1:0] m);
        case (m)
            3'd1:          return 3'd1;
            3'd2, 3'd4:    return 3'd2;
            3'd3, 3'd5,
            3'd6:          return 3'd3;
            3'd7:          return 3'd4;
            default:       return 3'd0;
        endcase
    endfunction

    // whether minor step idx of an operand phase is a bus step
    function automatic logic opnd_bus(input logic [MODE_W-1:0] m, input logic [2:0] idx);
        case (m)
            3'd1:                    return 1'b1;
            3'd2, 3'd3, 3'd4, 3'd5:  return idx != 3'd0;
            3'd6, 3'd7:              return idx != 3'd1;
            default:                 return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/seq_plan.sv
module seq_plan
    import major_seq_pkg::*;
#(
    parameter int STEP_W = 3
) (
    input  major_e              cur,
    input  logic [STEP_W-1:0]   idx,
    input  logic [MODE_W-1:0]   src_m,
    input  logic [MODE_W-1:0]   dst_m,
    input  logic                wb,
    output step_t               plan
);
    logic [2:0] len;
    logic       bus;

    always_comb begin
        len = 3'd1;
        bus = 1'b0;
        case (cur)
            MS_FETCH: begin len = 3'd2; bus = (idx == '0); end
            MS_SRC:   begin len = opnd_len(src_m); bus = opnd_bus(src_m, idx[2:0]); end
            MS_DST:   begin len = opnd_len(dst_m); bus = opnd_bus(dst_m, idx[2:0]); end
            MS_EXEC:  begin
                len = (wb && dst_m != '0) ? 3'd2 : 3'd1;
                bus = (idx != '0);
            end
            MS_SERV:  begin len = 3'd2; bus = 1'b1; end
            default:  begin len = 3'd1; bus = 1'b0; end
        endcase
    end

    always_comb begin
        plan.is_bus = bus;
        plan.last   = (idx[2:0] == len - 3'd1);
        if (!bus)
            plan.kind = BK_NONE;
        else if (cur == MS_EXEC)
            plan.kind = BK_WRHLD;
        else if (cur == MS_DST && plan.last)
            plan.kind = BK_RDPW;
        else
            plan.kind = BK_READ;
    end
endmodule

// File: rtl/seq_state.sv
module seq_state
    import major_seq_pkg::*;
#(
    parameter int STEP_W = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  step_t               plan,
    input  logic                bus_done,
    input  logic                irq_pend,
    input  logic [1:0]          cls_in,
    input  logic [MODE_W-1:0]   src_in,
    input  logic [MODE_W-1:0]   dst_in,
    input  logic                wb_in,
    output major_e              cur,
    output logic [STEP_W-1:0]   idx,
    output logic [MODE_W-1:0]   src_q,
    output logic [MODE_W-1:0]   dst_q,
    output logic                wb_q
);
    iclass_e            cls_q;
    iclass_e            cls_e;
    logic [MODE_W-1:0]  src_e, dst_e;
    logic               step_done;
    logic               capture;
    logic               has_src, has_dst;
    major_e             nxt;

    assign step_done = plan.is_bus ? bus_done : 1'b1;
    assign capture   = (cur == MS_FETCH) && step_done && plan.last;

    // decode values in force: live inputs at the end of Fetch, captured later
    assign cls_e = capture ? iclass_e'(cls_in) : cls_q;
    assign src_e = capture ? src_in : src_q;
    assign dst_e = capture ? dst_in : dst_q;

    assign has_src = (cls_e == IC_TWO) && (src_e != '0);
    assign has_dst = (cls_e == IC_ONE || cls_e == IC_TWO) && (dst_e != '0);

    always_comb begin
        case (cur)
            MS_FETCH: nxt = has_src ? MS_SRC : (has_dst ? MS_DST : MS_EXEC);
            MS_SRC:   nxt = has_dst ? MS_DST : MS_EXEC;
            MS_DST:   nxt = MS_EXEC;
            MS_EXEC:  nxt = irq_pend ? MS_SERV : MS_FETCH;
            default:  nxt = MS_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur   <= MS_FETCH;
            idx   <= '0;
            cls_q <= IC_NONE;
            src_q <= '0;
            dst_q <= '0;
            wb_q  <= 1'b0;
        end else begin
            if (capture) begin
                cls_q <= iclass_e'(cls_in);
                src_q <= src_in;
                dst_q <= dst_in;
                wb_q  <= wb_in;
            end
            if (step_done) begin
                if (plan.last) begin
                    cur <= nxt;
                    idx <= '0;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    // R11
    bus_wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (plan.is_bus && !bus_done) |=> ($stable(cur) && $stable(idx)));

    // R3
    src_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (cur == MS_SRC && $past(cur) != MS_SRC) |-> $past(cur) == MS_FETCH);

    // R9
    exec_exit_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(cur) == MS_EXEC && cur != MS_EXEC) |-> (cur == MS_FETCH || cur == MS_SERV));

    // R9
    serv_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (cur == MS_SERV && $past(cur) == MS_EXEC) |-> $past(irq_pend));

    // R10
    serv_exit_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(cur) == MS_SERV && cur != MS_SERV) |-> cur == MS_FETCH);
endmodule

// File: rtl/seq_addr_hold.sv
module seq_addr_hold
    import major_seq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  bkind_e            kind,
    input  logic              bus_done,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] bus_addr
);
    logic [ADDR_W-1:0] held_q;
    logic              is_read;

    assign is_read = (kind == BK_READ) || (kind == BK_RDPW);

    always_ff @(posedge clk) begin
        if (rst)
            held_q <= '0;
        else if (is_read && bus_done)
            held_q <= addr_in;
    end

    assign bus_addr = (kind == BK_WRHLD) ? held_q : addr_in;

    // R8
    held_during_write_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == BK_WRHLD && $past(kind) == BK_WRHLD) |-> $stable(bus_addr));
endmodule

// File: rtl/major_seq.sv
module major_seq
    import major_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        ins_class,
    input  logic [2:0]        src_mode,
    input  logic [2:0]        dst_mode,
    input  logic              wr_back,
    input  logic              bus_done,
    input  logic              irq_pend,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [2:0]        major,
    output logic [STEP_W-1:0] step,
    output logic              bus_req,
    output logic [1:0]        bus_kind,
    output logic [ADDR_W-1:0] bus_addr
);
    major_e             cur;
    logic [STEP_W-1:0]  idx;
    logic [MODE_W-1:0]  src_q, dst_q;
    logic               wb_q;
    step_t              plan;

    seq_plan #(.STEP_W(STEP_W)) u_plan (
        .cur   (cur),
        .idx   (idx),
        .src_m (src_q),
        .dst_m (dst_q),
        .wb    (wb_q),
        .plan  (plan)
    );

    seq_state #(.STEP_W(STEP_W)) u_state (
        .clk      (clk),
        .rst      (rst),
        .plan     (plan),
        .bus_done (bus_done),
        .irq_pend (irq_pend),
        .cls_in   (ins_class),
        .src_in   (src_mode),
        .dst_in   (dst_mode),
        .wb_in    (wr_back),
        .cur      (cur),
        .idx      (idx),
        .src_q    (src_q),
        .dst_q    (dst_q),
        .wb_q     (wb_q)
    );

    seq_addr_hold #(.ADDR_W(ADDR_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .kind     (plan.kind),
        .bus_done (bus_done),
        .addr_in  (addr_in),
        .bus_addr (bus_addr)
    );

    assign major    = cur;
    assign step     = idx;
    assign bus_req  = plan.is_bus;
    assign bus_kind = plan.kind;

    // R7
    write_in_exec_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_kind == 2'd3) |-> (major == 3'd3 && step != '0));

    // R6
    rdpw_in_dst_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_kind == 2'd2) |-> major == 3'd2);
endmodule

// File: tb/major_seq_bench.sv
module major_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  ins_class = '0;
    logic [2:0]  src_mode = '0;
    logic [2:0]  dst_mode = '0;
    logic        wr_back = 1'b0;
    logic        bus_done = 1'b0;
    logic        irq_pend = 1'b0;
    logic [15:0] addr_in = '0;
    logic [2:0]  major;
    logic [2:0]  step;
    logic        bus_req;
    logic [1:0]  bus_kind;
    logic [15:0] bus_addr;

    int checks = 0;
    int fails  = 0;
    logic [15:0] last_rd = '0;
    logic [15:0] addr_ctr = 16'h1000;

    always #5 clk = ~clk;

    major_seq u_major_seq (
        .clk(clk), .rst(rst), .ins_class(ins_class), .src_mode(src_mode),
        .dst_mode(dst_mode), .wr_back(wr_back), .bus_done(bus_done),
        .irq_pend(irq_pend), .addr_in(addr_in), .major(major), .step(step),
        .bus_req(bus_req), .bus_kind(bus_kind), .bus_addr(bus_addr)
    );

    // bench-side step tables, bit i set = bus step
    function automatic logic [3:0] pat(input logic [2:0] m);
        case (m)
            3'd1: return 4'b0001;
            3'd2: return 4'b0010;
            3'd3: return 4'b0110;
            3'd4: return 4'b0010;
            3'd5: return 4'b0110;
            3'd6: return 4'b0101;
            3'd7: return 4'b1101;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic int plen(input logic [2:0] m);
        case (m)
            3'd1: return 1;
            3'd2, 3'd4: return 2;
            3'd3, 3'd5, 3'd6: return 3;
            3'd7: return 4;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input int em, input int es, input int ek, input string tag);
        checks++;
        if (major != em[2:0] || step != es[2:0] || bus_kind != ek[1:0] || bus_req != (ek != 0)) begin
            fails++;
            $display("FAIL %s: major/step/kind/req = %0d/%0d/%0d/%0d, expected %0d/%0d/%0d/%0d",
                     tag, major, step, bus_kind, bus_req, em, es, ek, (ek != 0));
        end
    endtask

    // advance one minor step; bus steps stall for 'waits' cycles first (R11)
    task automatic adv(input bit isbus, input int waits);
        if (isbus) begin
            logic [2:0] m0, s0;
            logic [1:0] k0;
            m0 = major; s0 = step; k0 = bus_kind;
            if (bus_kind == 2'd1 || bus_kind == 2'd2) begin
                addr_ctr = addr_ctr + 16'h0012;
                addr_in  = addr_ctr;
                last_rd  = addr_ctr;
            end
            for (int w = 0; w < waits; w++) begin
                @(posedge clk); @(negedge clk);
                checks++;
                if (major != m0 || step != s0 || bus_kind != k0 || !bus_req) begin
                    fails++;
                    $display("FAIL R11: stalled state %0d/%0d/%0d, expected %0d/%0d/%0d",
                             major, step, bus_kind, m0, s0, k0);
                end
            end
            bus_done = 1'b1;
            @(posedge clk); @(negedge clk);
            bus_done = 1'b0;
        end else begin
            @(posedge clk); @(negedge clk);
        end
    endtask

    task automatic opnd_phase(input int code, input logic [2:0] m, input int waits, input string tag);
        for (int i = 0; i < plen(m); i++) begin
            int k;
            if (!pat(m)[i]) k = 0;
            else if (code == 2 && i == plen(m) - 1) k = 2;
            else k = 1;
            chk(code, i, k, tag);
            adv(pat(m)[i], waits);
        end
    endtask

    task automatic do_instr(input logic [1:0] cls, input logic [2:0] sm, input logic [2:0] dm,
                            input bit wb, input bit irq_early, input bit irq_late,
                            input int waits, input string tag);
        ins_class = cls; src_mode = sm; dst_mode = dm; wr_back = wb;
        irq_pend = irq_early;
        chk(0, 0, 1, {tag, " R2 fetch read"});
        adv(1'b1, waits);
        chk(0, 1, 0, {tag, " R2 fetch decode"});
        adv(1'b0, 0);
        // scramble decode inputs: captured values must rule (R2)
        ins_class = ~cls; src_mode = ~sm; dst_mode = ~dm; wr_back = ~wb;
        if (cls == 2'd2 && sm != 3'd0)
            opnd_phase(1, sm, waits, {tag, " R3 R5 R6 src"});
        if ((cls == 2'd1 || cls == 2'd2) && dm != 3'd0)
            opnd_phase(2, dm, waits, {tag, " R4 R5 R6 dst"});
        irq_pend = irq_late;
        chk(3, 0, 0, {tag, " R4 R7 exec"});
        adv(1'b0, 0);
        if (wb && dm != 3'd0) begin
            addr_in = 16'hBEEF;
            chk(3, 1, 3, {tag, " R7 write"});
            checks++;
            if (bus_addr != last_rd) begin
                fails++;
                $display("FAIL R8 %s: bus_addr %h, expected %h", tag, bus_addr, last_rd);
            end
            adv(1'b1, waits);
        end
        irq_pend = 1'b0;
        if (irq_late) begin
            chk(4, 0, 1, {tag, " R9 R10 serv0"});
            adv(1'b1, waits);
            chk(4, 1, 1, {tag, " R10 serv1"});
            adv(1'b1, 0);
        end
        chk(0, 0, 1, {tag, " R9 back to fetch"});
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(0, 0, 1, "R1 reset state");
    endtask

    task automatic t_no_operand();
        do_instr(2'd0, 3'd5, 3'd6, 1'b1, 1'b0, 1'b0, 0, "R4 class0");
        do_instr(2'd3, 3'd7, 3'd7, 1'b1, 1'b0, 1'b0, 1, "R4 class3");
    endtask

    task automatic t_reg_modes();
        do_instr(2'd1, 3'd0, 3'd0, 1'b1, 1'b0, 1'b0, 0, "R4 R7 single mode0");
        do_instr(2'd2, 3'd0, 3'd3, 1'b1, 1'b0, 1'b0, 0, "R3 src mode0");
        do_instr(2'd1, 3'd4, 3'd0, 1'b0, 1'b0, 1'b0, 0, "R3 single no src");
    endtask

    task automatic t_dst_modes();
        for (int m = 1; m < 8; m++)
            do_instr(2'd1, 3'd0, m[2:0], 1'b1, 1'b0, 1'b0, 2, "R5 R6 R8 dst sweep");
        do_instr(2'd1, 3'd6, 3'd2, 1'b0, 1'b0, 1'b0, 0, "R7 no wb");
    endtask

    task automatic t_src_modes();
        for (int m = 1; m < 8; m++)
            do_instr(2'd2, m[2:0], 3'd0, 1'b1, 1'b0, 1'b0, 1, "R3 R5 src sweep");
        do_instr(2'd2, 3'd7, 3'd6, 1'b1, 1'b0, 1'b0, 3, "R5 R8 both");
    endtask

    task automatic t_service();
        do_instr(2'd2, 3'd3, 3'd5, 1'b1, 1'b0, 1'b1, 1, "R9 R10 irq");
        do_instr(2'd0, 3'd0, 3'd0, 1'b0, 1'b1, 1'b1, 0, "R9 irq noop");
        do_instr(2'd1, 3'd0, 3'd1, 1'b1, 1'b1, 1'b0, 0, "R9 early irq dropped");
    endtask

    initial begin
        t_reset();
        t_no_operand();
        t_reg_modes();
        t_dst_modes();
        t_src_modes();
        t_service();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule